// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. It watches a counter value that is kept outside the block. It works in one of two ways. As an output-compare channel, it turns the counter into a pulse-width modulated level by comparing it with a compare value. As an input-capture channel, it stores the counter value whenever the selected input rises. A two-bit channel mode picks output operation or one of three capture sources. A two-bit output mode picks the waveform rule.

A fast-compare option shortens the trigger-to-output delay in the two PWM rules. A rising edge on the trigger input is treated as a compare match, so the output moves to its match level at once. Compare values pass through a shadow register when shadowing is asked for. Shadowing is also forced in PWM operation unless single-pulse operation is active.

The configuration is written in one cycle through a single write strobe, and two locks guard it. The channel mode cannot change while the channel is enabled. The waveform settings cannot change while protection level 3 is set and the channel is in output operation.

Top module: `tmr_chan_top`

## Requirements
- R1: While reset is held, the channel mode reads 00, the output mode reads 00, and `chOut`, `capStrobe` and `cmpActive` are all zero.
- R2: A configuration write does not change `modeOut` while `chanEn` is 1. It does change `modeOut` when `chanEn` is 0.
- R3: When `protLvl` is 3 and the channel mode is 00, a configuration write leaves the output mode, fast enable and shadow enable unchanged. It is still observable as a steady `ocModeOut`.
- R4: With output mode 01 (PWM rule 1) and channel mode 00, `chOut` is 1 one cycle after the counter is below `cmpActive`, and 0 otherwise.
- R5: With output mode 10 (PWM rule 2) and channel mode 00, `chOut` is the inverse of the rule in R4.
- R6: Fast compare applies when it is enabled and the channel is in PWM rule 1 or 2. A rising edge on `trigIn` then drives `chOut` to the match level one cycle later: 0 for rule 1, 1 for rule 2. The output stays at that level until the counter-versus-compare result changes.
- R7: A `trigIn` edge has no effect on `chOut` when fast compare is disabled, or when the output mode is 00 or 11.
- R8: When shadowing is in effect, a compare write reaches `cmpActive` only on `updateEvt`. Shadowing is in effect when the shadow enable is set, or when the channel is in PWM without `singlePulse`. Otherwise the write reaches `cmpActive` on the next cycle.
- R9: In channel mode 01, 10 or 11, a rising edge on `ownIn`, `nbrIn` or `itsIn` respectively pulses `capStrobe` for one cycle on the next cycle. At the same time `capValue` holds the counter sampled at that edge. Edges on the other sources are ignored, and `chOut` is 0.
- R10: Output mode 11 holds `chOut` at 1, and output mode 00 holds it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| counter | input | CNT_W | Shared timer count |
| cmpWrEn | input | 1 | Compare value write strobe |
| cmpWrVal | input | CNT_W | Compare value to write |
| updateEvt | input | 1 | Counter update event (shadow transfer) |
| singlePulse | input | 1 | Single-pulse operation active |
| chanEn | input | 1 | Channel enable (locks channel mode) |
| protLvl | input | 2 | Protection level, 3 locks waveform settings |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgMode | input | 2 | Channel mode: 00 output, 01/10/11 capture source |
| cfgOcMode | input | 2 | Output mode: 00 low, 01 PWM1, 10 PWM2, 11 high |
| cfgFastEn | input | 1 | Fast compare enable |
| cfgShadowEn | input | 1 | Compare shadow enable |
| trigIn | input | 1 | Trigger input |
| ownIn | input | 1 | Own filtered input |
| nbrIn | input | 1 | Neighbour channel filtered input |
| itsIn | input | 1 | Internal trigger signal |
| chOut | output | 1 | Channel output level |
| capStrobe | output | 1 | One-cycle capture pulse |
| capValue | output | CNT_W | Captured counter value |
| cmpActive | output | CNT_W | Active compare value |
| modeOut | output | 2 | Current channel mode |
| ocModeOut | output | 2 | Current output mode |

## Verification
The assertions assume that `chanEn` and `protLvl` change only on clock edges, like every other input. They also assume that the counter is sampled in the same cycle as a capture edge. The capture checks rely on each source input being held for at least one cycle, so that a rise is seen as a low-then-high pair of samples. The stimulus drives every input half a cycle away from the active edge. It never asserts `updateEvt` in the same cycle as a compare write, so the transfer order is never ambiguous.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int NSRC = 3;
  localparam logic [1:0] PROT_FULL = 2'b11;

  typedef enum logic [1:0] {
    CH_OUT    = 2'b00,
    CH_IN_OWN = 2'b01,
    CH_IN_NBR = 2'b10,
    CH_IN_TRG = 2'b11
  } chanMode_e;

  typedef enum logic [1:0] {
    OC_LOW  = 2'b00,
    OC_PWM1 = 2'b01,
    OC_PWM2 = 2'b10,
    OC_HIGH = 2'b11
  } ocMode_e;

  typedef struct packed {
    chanMode_e mode;
    ocMode_e   ocMode;
    logic      fastEn;
    logic      shadowEn;
  } chanCfg_t;

  typedef struct packed {
    logic trigEdge;
    logic capEdge;
    logic cmpWrShadow;
    logic cmpWrActive;
    logic updLoad;
  } chanStrobe_t;
endpackage

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl
  import tmr_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgMode,
  input  logic [1:0]        cfgOcMode,
  input  logic              cfgFastEn,
  input  logic              cfgShadowEn,
  input  logic              chanEn,
  input  logic [1:0]        protLvl,
  input  logic              singlePulse,
  input  logic              cmpWrEn,
  input  logic              updateEvt,
  input  logic              trigIn,
  input  logic [NSRC-1:0]   srcIn,
  output chanCfg_t          cfg,
  output chanStrobe_t       stb
);
  chanCfg_t        cfgQ;
  logic [NSRC-1:0] srcPrev;
  logic [NSRC-1:0] srcRise;
  logic [NSRC:0]   riseVec;
  logic            trigPrev;
  logic            modeLock;
  logic            ocLock;
  logic            isPwm;
  logic            effShadow;

  assign modeLock = chanEn;
  assign ocLock   = (protLvl == PROT_FULL) && (cfgQ.mode == CH_OUT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '{mode: CH_OUT, ocMode: OC_LOW, fastEn: 1'b0, shadowEn: 1'b0};
    end else if (cfgWrEn) begin
      if (!modeLock) cfgQ.mode <= chanMode_e'(cfgMode);
      if (!ocLock) begin
        cfgQ.ocMode   <= ocMode_e'(cfgOcMode);
        cfgQ.fastEn   <= cfgFastEn;
        cfgQ.shadowEn <= cfgShadowEn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPrev  <= '0;
      trigPrev <= 1'b0;
    end else begin
      srcPrev  <= srcIn;
      trigPrev <= trigIn;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_edge
    assign srcRise[i] = srcIn[i] & ~srcPrev[i];
  end

  // slot 0 stands for output mode and never captures
  assign riseVec = {srcRise, 1'b0};

  assign isPwm = (cfgQ.mode == CH_OUT) &&
                 ((cfgQ.ocMode == OC_PWM1) || (cfgQ.ocMode == OC_PWM2));
  assign effShadow = cfgQ.shadowEn | (isPwm & ~singlePulse);

  always_comb begin
    stb.trigEdge    = trigIn & ~trigPrev & cfgQ.fastEn & isPwm;
    stb.capEdge     = riseVec[cfgQ.mode];
    stb.cmpWrShadow = cmpWrEn;
    stb.cmpWrActive = cmpWrEn & ~effShadow;
    stb.updLoad     = updateEvt & effShadow;
  end

  assign cfg = cfgQ;
endmodule

// File: rtl/tmr_chan_dp.sv
module tmr_chan_dp
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanCfg_t         cfg,
  input  chanStrobe_t      stb,
  input  logic [CNT_W-1:0] counter,
  input  logic [CNT_W-1:0] cmpWrVal,
  output logic             chOut,
  output logic             capStrobe,
  output logic [CNT_W-1:0] capValue,
  output logic [CNT_W-1:0] cmpActive
);
  logic [CNT_W-1:0] shadowQ;
  logic [CNT_W-1:0] activeQ;
  logic             natLvl;
  logic             natPrevQ;
  logic             forceQ;
  logic             forceNext;
  logic             matchLvl;
  logic             outNext;
  logic             below;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '0;
      activeQ <= '0;
    end else begin
      if (stb.cmpWrShadow) shadowQ <= cmpWrVal;
      if (stb.cmpWrActive) activeQ <= cmpWrVal;
      else if (stb.updLoad) activeQ <= shadowQ;
    end
  end

  assign below = counter < activeQ;

  always_comb begin
    unique case (cfg.ocMode)
      OC_PWM1: natLvl = below;
      OC_PWM2: natLvl = ~below;
      OC_HIGH: natLvl = 1'b1;
      default: natLvl = 1'b0;
    endcase
  end

  assign matchLvl  = (cfg.ocMode == OC_PWM2);
  assign forceNext = stb.trigEdge | (forceQ & (natLvl == natPrevQ));
  assign outNext   = (cfg.mode != CH_OUT) ? 1'b0 : (forceNext ? matchLvl : natLvl);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      natPrevQ  <= 1'b0;
      forceQ    <= 1'b0;
      chOut     <= 1'b0;
      capStrobe <= 1'b0;
      capValue  <= '0;
    end else begin
      natPrevQ  <= natLvl;
      forceQ    <= forceNext;
      chOut     <= outNext;
      capStrobe <= stb.capEdge;
      if (stb.capEdge) capValue <= counter;
    end
  end

  assign cmpActive = activeQ;
endmodule

// File: rtl/tmr_chan_top.sv
module tmr_chan_top
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] counter,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrVal,
  input  logic             updateEvt,
  input  logic             singlePulse,
  input  logic             chanEn,
  input  logic [1:0]       protLvl,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgMode,
  input  logic [1:0]       cfgOcMode,
  input  logic             cfgFastEn,
  input  logic             cfgShadowEn,
  input  logic             trigIn,
  input  logic             ownIn,
  input  logic             nbrIn,
  input  logic             itsIn,
  output logic             chOut,
  output logic             capStrobe,
  output logic [CNT_W-1:0] capValue,
  output logic [CNT_W-1:0] cmpActive,
  output logic [1:0]       modeOut,
  output logic [1:0]       ocModeOut
);
  chanCfg_t    cfg;
  chanStrobe_t stb;

  tmr_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .cfgOcMode(cfgOcMode), .cfgFastEn(cfgFastEn), .cfgShadowEn(cfgShadowEn),
    .chanEn(chanEn), .protLvl(protLvl), .singlePulse(singlePulse),
    .cmpWrEn(cmpWrEn), .updateEvt(updateEvt), .trigIn(trigIn),
    .srcIn({itsIn, nbrIn, ownIn}), .cfg(cfg), .stb(stb)
  );

  tmr_chan_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .counter(counter),
    .cmpWrVal(cmpWrVal), .chOut(chOut), .capStrobe(capStrobe),
    .capValue(capValue), .cmpActive(cmpActive)
  );

  assign modeOut   = cfg.mode;
  assign ocModeOut = cfg.ocMode;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] counter,
  input logic             chanEn,
  input logic [1:0]       protLvl,
  input logic             chOut,
  input logic             capStrobe,
  input logic [CNT_W-1:0] capValue,
  input logic [1:0]       modeOut,
  input logic [1:0]       ocModeOut
);
  // R2
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanEn |=> $stable(modeOut));

  // R3
  prot_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (protLvl == 2'b11 && modeOut == 2'b00) |=> $stable(ocModeOut));

  // R9
  cap_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |-> capValue == $past(counter));

  // R9
  cap_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |-> $past(modeOut) != 2'b00);

  // R9
  in_mode_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeOut) != 2'b00) |-> !chOut);
endmodule

bind tmr_chan_top tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .counter(counter), .chanEn(chanEn),
  .protLvl(protLvl), .chOut(chOut), .capStrobe(capStrobe),
  .capValue(capValue), .modeOut(modeOut), .ocModeOut(ocModeOut)
);

// File: tb/sim_tmr_chan_top.sv
module sim_tmr_chan_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN;
  logic [CNT_W-1:0] counter, cmpWrVal, capValue, cmpActive;
  logic cmpWrEn, updateEvt, singlePulse, chanEn, cfgWrEn, cfgFastEn, cfgShadowEn;
  logic [1:0] protLvl, cfgMode, cfgOcMode, modeOut, ocModeOut;
  logic trigIn, ownIn, nbrIn, itsIn, chOut, capStrobe;

  int nChk = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  tmr_chan_top #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .counter(counter), .cmpWrEn(cmpWrEn),
    .cmpWrVal(cmpWrVal), .updateEvt(updateEvt), .singlePulse(singlePulse),
    .chanEn(chanEn), .protLvl(protLvl), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .cfgOcMode(cfgOcMode), .cfgFastEn(cfgFastEn), .cfgShadowEn(cfgShadowEn),
    .trigIn(trigIn), .ownIn(ownIn), .nbrIn(nbrIn), .itsIn(itsIn),
    .chOut(chOut), .capStrobe(capStrobe), .capValue(capValue),
    .cmpActive(cmpActive), .modeOut(modeOut), .ocModeOut(ocModeOut)
  );

  // {ocMode[1:0], counter[7:0], expected chOut}, compare value 0x40
  localparam int NVEC = 11;
  localparam logic [10:0] VEC [NVEC] = '{
    {2'b01, 8'h00, 1'b1}, {2'b01, 8'h3F, 1'b1}, {2'b01, 8'h40, 1'b0},
    {2'b01, 8'hFF, 1'b0}, {2'b10, 8'h3F, 1'b0}, {2'b10, 8'h40, 1'b1},
    {2'b10, 8'h10, 1'b0}, {2'b11, 8'h00, 1'b1}, {2'b00, 8'h80, 1'b0},
    {2'b01, 8'h41, 1'b0}, {2'b10, 8'hC0, 1'b1}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [1:0] m, input logic [1:0] oc, input logic f, input logic s);
    cfgWrEn = 1'b1; cfgMode = m; cfgOcMode = oc; cfgFastEn = f; cfgShadowEn = s;
    tick();
    cfgWrEn = 1'b0;
  endtask

  task automatic writeCmp(input logic [CNT_W-1:0] v);
    cmpWrEn = 1'b1; cmpWrVal = v;
    tick();
    cmpWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    rstN = 1'b0; counter = '0; cmpWrEn = 0; cmpWrVal = '0; updateEvt = 0;
    singlePulse = 0; chanEn = 0; protLvl = 2'b00; cfgWrEn = 0; cfgMode = 0;
    cfgOcMode = 0; cfgFastEn = 0; cfgShadowEn = 0; trigIn = 0; ownIn = 0;
    nbrIn = 0; itsIn = 0;
    repeat (3) tick();
    check(modeOut == 2'b00 && ocModeOut == 2'b00, "R1 modes", {modeOut, ocModeOut}, 0);
    check(!chOut && !capStrobe && cmpActive == 0, "R1 outputs", {chOut, capStrobe, cmpActive}, 0);
    rstN = 1'b1;
    tick();

    writeCmp(16'h0040);
    check(cmpActive == 16'h0040, "R8 immediate load", cmpActive, 16'h0040);

    for (int i = 0; i < NVEC; i++) begin
      cfgWrEn = 1'b1; cfgMode = 2'b00; cfgOcMode = VEC[i][10:9];
      cfgFastEn = 0; cfgShadowEn = 0; counter = {8'h00, VEC[i][8:1]};
      tick();
      cfgWrEn = 1'b0;
      tick();
      check(chOut == VEC[i][0],
            (VEC[i][10:9] == 2'b01) ? "R4 pwm1" : (VEC[i][10:9] == 2'b10) ? "R5 pwm2" : "R10 fixed",
            chOut, VEC[i][0]);
    end

    // R6 fast compare, PWM rule 1
    counter = 16'h0010;
    writeCfg(2'b00, 2'b01, 1'b1, 1'b0);
    tick();
    check(chOut == 1'b1, "R6 pre", chOut, 1);
    trigIn = 1'b1; tick();
    check(chOut == 1'b0, "R6 forced pwm1", chOut, 0);
    tick();
    check(chOut == 1'b0, "R6 held", chOut, 0);
    counter = 16'h0050; tick();
    check(chOut == 1'b0, "R6 natural low", chOut, 0);
    counter = 16'h0010; tick();
    check(chOut == 1'b1, "R6 released", chOut, 1);
    trigIn = 1'b0; tick();

    // R6 fast compare, PWM rule 2
    writeCfg(2'b00, 2'b10, 1'b1, 1'b0);
    tick();
    check(chOut == 1'b0, "R6 pwm2 pre", chOut, 0);
    trigIn = 1'b1; tick();
    check(chOut == 1'b1, "R6 forced pwm2", chOut, 1);
    trigIn = 1'b0; tick();

    // R7 no effect
    writeCfg(2'b00, 2'b01, 1'b0, 1'b0);
    tick();
    trigIn = 1'b1; tick();
    check(chOut == 1'b1, "R7 fast off", chOut, 1);
    trigIn = 1'b0;
    writeCfg(2'b00, 2'b11, 1'b1, 1'b0);
    tick();
    trigIn = 1'b1; tick();
    check(chOut == 1'b1, "R7 high mode", chOut, 1);
    trigIn = 1'b0; tick();

    // R8 shadow behaviour
    writeCfg(2'b00, 2'b01, 1'b0, 1'b0);
    writeCmp(16'h0020);
    check(cmpActive == 16'h0040, "R8 pwm shadowed", cmpActive, 16'h0040);
    updateEvt = 1'b1; tick(); updateEvt = 1'b0;
    check(cmpActive == 16'h0020, "R8 update load", cmpActive, 16'h0020);
    singlePulse = 1'b1;
    writeCmp(16'h0030);
    check(cmpActive == 16'h0030, "R8 single pulse direct", cmpActive, 16'h0030);
    singlePulse = 1'b0;
    writeCfg(2'b00, 2'b00, 1'b0, 1'b1);
    writeCmp(16'h0060);
    check(cmpActive == 16'h0030, "R8 shadow enable", cmpActive, 16'h0030);
    updateEvt = 1'b1; tick(); updateEvt = 1'b0;
    check(cmpActive == 16'h0060, "R8 shadow update", cmpActive, 16'h0060);

    // R3 protection lock
    protLvl = 2'b11;
    writeCfg(2'b00, 2'b10, 1'b0, 1'b0);
    check(ocModeOut == 2'b00, "R3 locked", ocModeOut, 0);
    protLvl = 2'b00;
    writeCfg(2'b00, 2'b10, 1'b0, 1'b0);
    check(ocModeOut == 2'b10, "R3 unlocked", ocModeOut, 2);

    // R9 capture
    writeCfg(2'b01, 2'b00, 1'b0, 1'b0);
    check(modeOut == 2'b01, "R2 write when disabled", modeOut, 1);
    counter = 16'h0033; ownIn = 1'b1; tick();
    check(capStrobe && capValue == 16'h0033, "R9 own capture", capValue, 16'h0033);
    tick();
    check(!capStrobe, "R9 strobe one cycle", capStrobe, 0);
    ownIn = 1'b0;
    writeCfg(2'b10, 2'b00, 1'b0, 1'b0);
    counter = 16'h0044; ownIn = 1'b1; tick();
    check(!capStrobe, "R9 wrong source ignored", capStrobe, 0);
    counter = 16'h0045; nbrIn = 1'b1; tick();
    check(capStrobe && capValue == 16'h0045, "R9 nbr capture", capValue, 16'h0045);
    check(!chOut, "R9 output low in input", chOut, 0);
    writeCfg(2'b11, 2'b00, 1'b0, 1'b0);
    counter = 16'h0046; itsIn = 1'b1; tick();
    check(capStrobe && capValue == 16'h0046, "R9 its capture", capValue, 16'h0046);

    // R2 mode lock
    chanEn = 1'b1;
    writeCfg(2'b00, 2'b00, 1'b0, 1'b0);
    check(modeOut == 2'b11, "R2 locked", modeOut, 3);
    chanEn = 1'b0;
    writeCfg(2'b00, 2'b00, 1'b0, 1'b0);
    check(modeOut == 2'b00, "R2 unlocked", modeOut, 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule